// File: doc/BRIEF.md
# Serial-Programmed 128-Step Potentiometer Controller

This block is the digital control side of a potentiometer with 128 settings that a host programs over a four-wire serial link: active-low select, serial clock, data in and data out. It keeps a volatile wiper value that drives a 7-bit tap code, and a modelled non-volatile start value. Leaving reset, the block copies the start value into the wiper, so the tap comes up where the start value says.

Each transaction is three bytes, most significant bit first, clocked in on rising serial-clock edges. The first byte identifies the device. The second byte carries a 4-bit command and a 4-bit register select. The third byte is the write data, or a filler byte during a read. A read drives the selected register out on the data output, and the host samples it on falling serial-clock edges. Writing the start value takes effect when select is released and then holds the block busy for a fixed number of clock cycles. Any transaction that begins while the block is busy is dropped. All serial inputs are synchronised into the system clock, so the serial clock must run several times slower than the system clock.

Top module: `dpot_ctrl`

## Requirements
- R1: Leaving reset, `tap` equals the start value, which itself resets to parameter `NV_DEFAULT`. `busy` and `miso_oe` are low.
- R2: A transaction whose first byte is not 0x50 changes nothing, and `miso_oe` stays low for its whole length.
- R3: Command 0x20 (bits 7:4 = 0x2 write, bits 3:0 = 0 wiper) followed by data D sets `tap` to D[6:0] once the eighth data bit has been clocked in. D[7] is ignored.
- R4: Commands 0x30 (wiper) and 0x31 (start value) read back. From the eighth command bit until the eighth filler bit, `miso_oe` is high and `miso` presents {0, value}, MSB first, with one bit valid at each falling serial-clock edge.
- R5: `miso_oe` is low whenever the block is not selected. It drops within three clock cycles of select going high.
- R6: Command 0x21 with data D stores D[6:0] as the start value when select rises. `busy` then stays high for exactly `NV_WRITE_CYCLES` cycles.
- R7: A transaction whose select fall reaches the block while `busy` is high has no effect. One that begins after `busy` is low is served normally.
- R8: After reset, nothing is accepted until select has been seen high and then low. Bits clocked while select is held low from reset are ignored.
- R9: A command with any other opcode, or with a register select other than 0 or 1, is ignored for the rest of the transaction.
- R10: A write in which select rises before all eight data bits are clocked in has no effect.
- R11: Bytes clocked after the third byte of a transaction are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the miso pad; low means high impedance |
| tap | output | TAP_BITS | Wiper tap code |
| busy | output | 1 | Non-volatile write interval in progress |

## Verification
Two things can land on the same clock edge: the busy interval ending, and a new select fall arriving through the synchroniser. The bench provokes this by starting a wiper write at a sweep of offsets around the end of each busy interval.

Each outcome is judged against the `busy` value the bench sees. If `busy` was already low when select fell, the write must take effect. If `busy` was still high three cycles after the fall, the write must be dropped. In between, either outcome is allowed, but the tap must hold exactly the old value or exactly the new one.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
    localparam logic [7:0] ID_BYTE   = 8'h50;
    localparam logic [3:0] OP_WRITE  = 4'h2;
    localparam logic [3:0] OP_READ   = 4'h3;
    localparam logic [3:0] SEL_WIPER = 4'h0;
    localparam logic [3:0] SEL_START = 4'h1;

    typedef enum logic [2:0] {
        ST_RECALL,
        ST_IDLE,
        ST_ID,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } st_e;
endpackage

// File: rtl/dpot_sync.sv
module dpot_sync #(
    parameter int           STAGES  = 2,
    parameter int           W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dpot_nvtimer.sv
module dpot_nvtimer #(
    parameter int CYCLES = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end else if (start) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CW'(CYCLES - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = t_q.busy;
endmodule

// File: rtl/dpot_ctrl.sv
module dpot_ctrl
    import dpot_pkg::*;
#(
    parameter int                 TAP_BITS        = 7,
    parameter logic [TAP_BITS-1:0] NV_DEFAULT     = TAP_BITS'(64),
    parameter int                 NV_WRITE_CYCLES = 4000,
    parameter int                 SYNC_STAGES     = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                mosi,
    output logic                miso,
    output logic                miso_oe,
    output logic [TAP_BITS-1:0] tap,
    output logic                busy
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        st_e                 state;
        logic                cs_prev;
        logic                sck_prev;
        logic [CNT_W-1:0]    bitcnt;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic                oe;
        logic                is_wr;
        logic                to_start;
        logic [TAP_BITS-1:0] wiper;
        logic [TAP_BITS-1:0] nv;
        logic                nv_pend;
        logic [TAP_BITS-1:0] nv_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]        sync_out;
    logic              s_cs, s_sck, s_mosi;
    logic              cs_fall, cs_rise, sck_rise;
    logic              recall;
    logic              nv_start;
    logic [BYTE_W-1:0] byte_v;
    logic [3:0]        op, sel;
    logic              sel_ok;

    dpot_sync #(
        .STAGES (SYNC_STAGES),
        .W      (3),
        .RST_VAL(3'b000)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({cs_n, sclk, mosi}),
        .dout (sync_out)
    );

    assign {s_cs, s_sck, s_mosi} = sync_out;

    dpot_nvtimer #(
        .CYCLES(NV_WRITE_CYCLES)
    ) i_nvtimer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(nv_start),
        .busy (busy)
    );

    assign cs_fall  = r_q.cs_prev & ~s_cs;
    assign cs_rise  = ~r_q.cs_prev & s_cs;
    assign sck_rise = ~r_q.sck_prev & s_sck;
    assign recall   = (r_q.state == ST_RECALL);

    always_comb begin
        r_d      = r_q;
        nv_start = 1'b0;
        byte_v   = {r_q.rx[BYTE_W-2:0], s_mosi};
        op       = byte_v[7:4];
        sel      = byte_v[3:0];
        sel_ok   = (sel == SEL_WIPER) || (sel == SEL_START);

        r_d.cs_prev  = s_cs;
        r_d.sck_prev = s_sck;

        if (recall) begin
            r_d.wiper = r_q.nv;
            r_d.state = ST_IDLE;
        end else if (cs_rise) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
            if (r_q.nv_pend) begin
                r_d.nv      = r_q.nv_data;
                r_d.nv_pend = 1'b0;
                nv_start    = 1'b1;
            end
        end else if (cs_fall) begin
            r_d.bitcnt  = '0;
            r_d.oe      = 1'b0;
            r_d.nv_pend = 1'b0;
            r_d.state   = busy ? ST_DONE : ST_ID;
        end else if (sck_rise && (r_q.state inside {ST_ID, ST_CMD, ST_DATA})) begin
            r_d.rx     = byte_v;
            r_d.bitcnt = CNT_W'(r_q.bitcnt + 1'b1);
            if (r_q.oe) begin
                r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
            end
            if (r_q.bitcnt == CNT_W'(BYTE_W - 1)) begin
                unique case (r_q.state)
                    ST_ID: begin
                        r_d.state = (byte_v == ID_BYTE) ? ST_CMD : ST_DONE;
                    end
                    ST_CMD: begin
                        r_d.to_start = (sel == SEL_START);
                        if (op == OP_READ && sel_ok) begin
                            r_d.is_wr = 1'b0;
                            r_d.oe    = 1'b1;
                            r_d.tx    = (sel == SEL_START) ? BYTE_W'(r_q.nv)
                                                           : BYTE_W'(r_q.wiper);
                            r_d.state = ST_DATA;
                        end else if (op == OP_WRITE && sel_ok) begin
                            r_d.is_wr = 1'b1;
                            r_d.state = ST_DATA;
                        end else begin
                            r_d.state = ST_DONE;
                        end
                    end
                    ST_DATA: begin
                        r_d.oe    = 1'b0;
                        r_d.state = ST_DONE;
                        if (r_q.is_wr) begin
                            if (r_q.to_start) begin
                                r_d.nv_pend = 1'b1;
                                r_d.nv_data = byte_v[TAP_BITS-1:0];
                            end else begin
                                r_d.wiper = byte_v[TAP_BITS-1:0];
                            end
                        end
                    end
                    default: r_d.state = ST_DONE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_RECALL;
            r_q.nv    <= NV_DEFAULT;
        end else begin
            r_q <= r_d;
        end
    end

    assign tap     = r_q.wiper;
    assign miso_oe = r_q.oe;
    assign miso    = r_q.oe & r_q.tx[BYTE_W-1];
endmodule

// File: rtl/dpot_ctrl_chk.sv
module dpot_ctrl_chk #(
    parameter int TW     = 7,
    parameter int CYCLES = 4000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_rise,
    input logic          cs_fall,
    input logic          sck_rise,
    input logic          recall,
    input logic          nv_start,
    input logic          busy,
    input logic          miso_oe,
    input logic [TW-1:0] tap
);
    localparam int RW = $clog2(CYCLES + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (busy) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    p_oe_off_on_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe);

    p_tap_moves_on_sck_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!sck_rise && !recall) |=> $stable(tap));

    p_busy_follows_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nv_start |=> busy);

    p_busy_length_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == RW'(CYCLES)));

    p_select_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && busy) |=> !miso_oe);

    p_tap_frozen_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tap));
endmodule

bind dpot_ctrl dpot_ctrl_chk #(
    .TW    (TAP_BITS),
    .CYCLES(NV_WRITE_CYCLES)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_rise (cs_rise),
    .cs_fall (cs_fall),
    .sck_rise(sck_rise),
    .recall  (recall),
    .nv_start(nv_start),
    .busy    (busy),
    .miso_oe (miso_oe),
    .tap     (tap)
);

// File: tb/test_dpot_ctrl.sv
`timescale 1ns/1ps
module test_dpot_ctrl;
    localparam int         CYC    = 300;
    localparam logic [6:0] NV_DEF = 7'd64;
    localparam int         HALF   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0;
    logic sclk = 1'b0;
    logic mosi = 1'b0;
    logic miso, miso_oe, busy;
    logic [6:0] tap;

    int errors = 0;
    int checks = 0;
    int run_cnt = 0;
    int last_len = 0;
    bit done = 1'b0;
    logic bsy_at_fall, bsy_late;
    logic [6:0] exp_wiper, exp_nv;

    always #2.5 clk = ~clk;

    dpot_ctrl #(
        .TAP_BITS       (7),
        .NV_DEFAULT     (NV_DEF),
        .NV_WRITE_CYCLES(CYC),
        .SYNC_STAGES    (2)
    ) i_dpot_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .mosi   (mosi),
        .miso   (miso),
        .miso_oe(miso_oe),
        .tap    (tap),
        .busy   (busy)
    );

    always @(negedge clk) begin
        if (busy) begin
            run_cnt <= run_cnt + 1;
        end else begin
            if (run_cnt != 0) last_len <= run_cnt;
            run_cnt <= 0;
        end
    end

    function automatic logic [7:0] f_read_exp(input bit from_start);
        return from_start ? {1'b0, exp_nv} : {1'b0, exp_wiper};
    endfunction

    function automatic logic [31:0] f_frame(input logic [7:0] id, input logic [7:0] cmd,
                                            input logic [7:0] dat);
        return {id, cmd, dat, 8'h00};
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi(input logic [31:0] data, input int nbits, output logic [7:0] rd,
                       output bit oe_any, output bit oe_ok);
        rd = 8'h00;
        oe_any = 1'b0;
        oe_ok = 1'b1;
        bsy_at_fall = busy;
        cs_n = 1'b0;
        wait_clk(3);
        bsy_late = busy;
        wait_clk(3);
        for (int k = 0; k < nbits; k++) begin
            mosi = data[31-k];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            if (miso_oe) oe_any = 1'b1;
            if (k >= 15 && k <= 22) begin
                rd = {rd[6:0], miso};
                if (!miso_oe) oe_ok = 1'b0;
            end else if (miso_oe) begin
                oe_ok = 1'b0;
            end
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic wait_idle();
        while (busy) wait_clk(1);
        wait_clk(2);
    endtask

    initial begin
        logic [7:0] rd;
        logic [7:0] v;
        bit oe_any, oe_ok;
        logic [6:0] old;
        void'($urandom(32'd1234));
        exp_wiper = NV_DEF;
        exp_nv = NV_DEF;
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: recall of start value on leaving reset
        chk("R1", "tap after reset", tap, NV_DEF);
        chk("R1", "busy after reset", busy, 0);
        chk("R1", "oe after reset", miso_oe, 0);
        // R8: select held low since reset, no fall seen yet
        for (int k = 0; k < 24; k++) begin
            mosi = f_frame(8'h50, 8'h20, 8'h11)[31-k];
            wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
        end
        wait_clk(4);
        chk("R8", "tap without select fall", tap, NV_DEF);
        cs_n = 1'b1;
        wait_clk(8);
        // R3: wiper writes, bit 7 ignored
        spi(f_frame(8'h50, 8'h20, 8'h55), 24, rd, oe_any, oe_ok);
        exp_wiper = 7'h55;
        chk("R3", "tap write 55", tap, exp_wiper);
        spi(f_frame(8'h50, 8'h20, 8'hAA), 24, rd, oe_any, oe_ok);
        exp_wiper = 7'h2A;
        chk("R3", "tap write AA", tap, exp_wiper);
        // R4: read wiper
        spi(f_frame(8'h50, 8'h30, 8'hFF), 24, rd, oe_any, oe_ok);
        chk("R4", "read wiper", rd, f_read_exp(1'b0));
        chk("R4", "oe window", oe_ok, 1);
        chk("R5", "oe after release", miso_oe, 0);
        // R2: bad id
        spi(f_frame(8'h51, 8'h20, 8'h07), 24, rd, oe_any, oe_ok);
        chk("R2", "tap after bad id", tap, exp_wiper);
        spi(f_frame(8'hD0, 8'h30, 8'h00), 24, rd, oe_any, oe_ok);
        chk("R2", "oe during bad-id read", oe_any, 0);
        // R9: bad opcode and bad register select
        spi(f_frame(8'h50, 8'h40, 8'h09), 24, rd, oe_any, oe_ok);
        chk("R9", "tap after bad opcode", tap, exp_wiper);
        spi(f_frame(8'h50, 8'h22, 8'h0A), 24, rd, oe_any, oe_ok);
        chk("R9", "tap after bad select", tap, exp_wiper);
        spi(f_frame(8'h50, 8'h32, 8'h00), 24, rd, oe_any, oe_ok);
        chk("R9", "oe for bad-select read", oe_any, 0);
        // R10: aborted write
        spi(f_frame(8'h50, 8'h20, 8'h0B), 20, rd, oe_any, oe_ok);
        chk("R10", "tap after aborted write", tap, exp_wiper);
        // R11: extra byte ignored
        spi({8'h50, 8'h20, 8'h33, 8'h44}, 32, rd, oe_any, oe_ok);
        exp_wiper = 7'h33;
        chk("R11", "tap after extra byte", tap, exp_wiper);
        // R6: start value write and busy length
        spi(f_frame(8'h50, 8'h21, 8'h95), 24, rd, oe_any, oe_ok);
        exp_nv = 7'h15;
        chk("R6", "busy after commit", busy, 1);
        chk("R6", "tap unchanged by start write", tap, exp_wiper);
        // R7: transaction during busy
        spi(f_frame(8'h50, 8'h20, 8'h01), 24, rd, oe_any, oe_ok);
        chk("R7", "tap after write during busy", tap, exp_wiper);
        wait_idle();
        chk("R6", "busy length", last_len, CYC);
        spi(f_frame(8'h50, 8'h31, 8'h00), 24, rd, oe_any, oe_ok);
        chk("R6", "read start value", rd, f_read_exp(1'b1));
        chk("R4", "oe window start read", oe_ok, 1);
        spi(f_frame(8'h50, 8'h20, 8'h02), 24, rd, oe_any, oe_ok);
        exp_wiper = 7'h02;
        chk("R7", "tap after busy ends", tap, exp_wiper);
        // random mix
        for (int n = 0; n < 40; n++) begin
            int op;
            op = $urandom_range(0, 5);
            v = 8'($urandom);
            wait_idle();
            case (op)
                0: begin
                    spi(f_frame(8'h50, 8'h20, v), 24, rd, oe_any, oe_ok);
                    exp_wiper = v[6:0];
                    chk("R3", "random wiper write", tap, exp_wiper);
                end
                1: begin
                    spi(f_frame(8'h50, 8'h21, v), 24, rd, oe_any, oe_ok);
                    exp_nv = v[6:0];
                    wait_idle();
                    chk("R6", "random busy length", last_len, CYC);
                end
                2: begin
                    spi(f_frame(8'h50, 8'h30, v), 24, rd, oe_any, oe_ok);
                    chk("R4", "random wiper read", rd, f_read_exp(1'b0));
                end
                3: begin
                    spi(f_frame(8'h50, 8'h31, v), 24, rd, oe_any, oe_ok);
                    chk("R4", "random start read", rd, f_read_exp(1'b1));
                end
                4: begin
                    spi(f_frame(v | 8'h01, 8'h20, v), 24, rd, oe_any, oe_ok);
                    chk("R2", "random bad id", tap, exp_wiper);
                end
                default: begin
                    spi(f_frame(8'h50, {4'h5 + 4'(v[1:0]), v[3:0]}, v), 24, rd, oe_any, oe_ok);
                    chk("R9", "random bad opcode", tap, exp_wiper);
                end
            endcase
        end
        // race: select fall around the end of busy
        for (int d = 0; d < 6; d++) begin
            wait_idle();
            v = 8'($urandom);
            spi(f_frame(8'h50, 8'h21, v), 24, rd, oe_any, oe_ok);
            exp_nv = v[6:0];
            while (busy && run_cnt < CYC - 2 + d) wait_clk(1);
            old = exp_wiper;
            v = {1'b0, 7'(old + 7'd37)};
            spi(f_frame(8'h50, 8'h20, v), 24, rd, oe_any, oe_ok);
            if (!bsy_at_fall) begin
                exp_wiper = v[6:0];
                chk("R7", "race accepted", tap, exp_wiper);
            end else if (bsy_late) begin
                chk("R7", "race dropped", tap, old);
            end else begin
                chk("R7", "race all-or-nothing", (tap == old) || (tap == v[6:0]), 1);
                exp_wiper = tap;
            end
        end
        wait_idle();
        spi(f_frame(8'h50, 8'h31, 8'h00), 24, rd, oe_any, oe_ok);
        chk("R6", "final start read", rd, f_read_exp(1'b1));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule